// File: doc/BRIEF.md
# Smartcard Character Transceiver

This block carries asynchronous smartcard characters in both directions over one shared open-drain data wire. The output can only pull the wire low or let it float high. A character on the wire is a low start bit, eight data bits sent least significant bit first, one even parity bit, and a guard period of one and a half bit times. All bit timing comes from a baud tick enable, `tick_i`, that pulses sixteen times per bit. Ticks are numbered from the tick at which an event happens.

A parent writes a byte through a valid/ready pair. The transmitter waits half a bit before it starts the character. During the guard period it samples the wire to see whether the card signalled a parity error. It reports the result with a one-cycle done pulse and a sticky NACK flag. When the transmitter is idle, the receiver watches the wire for a start bit. It samples each bit in the middle of the bit and presents the byte with a valid pulse and a parity-error flag. On bad parity it pulls the wire low for one bit time during the stop period, so the sender can see the error. Only one direction is active at a time.

Top module: `sc_xcvr`

## Requirements
- R1: `tx_ready_o` is 1 only while no character is being sent or received. A byte is taken in the cycle where `tx_valid_i` and `tx_ready_o` are both 1. `tx_ready_o` is 0 from that cycle until the character's done pulse, and it is 0 during a reception.
- R2: After acceptance the wire stays released for 8 ticks (half a bit). `line_drive_low_o` goes to 1 after the 8th tick, and the start bit lasts 16 ticks.
- R3: Each sent bit lasts 16 ticks. `line_drive_low_o`=1 means the wire is pulled low, which is a 0 bit. The bits are sent in this order: start (0), data bit 0 through data bit 7, then a parity bit that makes the total count of ones over data and parity even.
- R4: After the parity bit the transmitter releases the wire for 24 ticks. `tx_done_o` is a one-cycle pulse that rises after the 192nd tick following acceptance.
- R5: The transmitter samples the wire at the 185th tick after acceptance, which is 16 ticks into the guard period. With the done pulse, `tx_nack_o` is 1 exactly when the wire was low at that sample. The flag holds until the next byte is accepted.
- R6: The receiver only watches the wire while the transmitter is idle. A low wire on a tick starts a reception, and that tick is tick 0. If the wire is high again at tick 8, the start is dropped and no `rx_valid_o` is produced.
- R7: The receiver samples bit i (0 is the start bit, 9 is the parity bit) at tick 8+16i. `rx_valid_o` is a one-cycle pulse after tick 152. It comes with `rx_data_o` (bit 0 is the first data bit on the wire) and `rx_perr_o`=1 when the ones count over data and parity is odd.
- R8: On a parity error the receiver pulls the wire low from after tick 168 up to tick 184, which is 16 ticks. The receiver drives the wire at no other time.
- R9: A reception ends, and `tx_ready_o` returns to 1, after tick 184. The exception is `rx_half_stop_i`=1 with good parity: then it ends after tick 168.
- R10: Only one side drives the wire at a time. While the block is transmitting, the receiver produces no `rx_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Baud tick enable, 16 per bit |
| rx_half_stop_i | input | 1 | Short (half-bit) receive stop when parity is good |
| tx_valid_i | input | 1 | Byte offered for sending |
| tx_data_i | input | 8 | Byte to send |
| tx_ready_o | output | 1 | Byte can be taken |
| tx_done_o | output | 1 | One-cycle end-of-character pulse |
| tx_nack_o | output | 1 | Card signalled a parity error for the last sent character |
| line_drive_low_o | output | 1 | 1 pulls the shared wire low, 0 releases it |
| line_i | input | 1 | Sampled level of the shared wire |
| rx_valid_o | output | 1 | One-cycle received-byte pulse |
| rx_data_o | output | 8 | Received byte |
| rx_perr_o | output | 1 | Received byte had odd parity |

## Verification
All timing is counted in ticks, not clock cycles, and the bench numbers ticks from the edge of each event. Start-bit lead is 8 ticks after acceptance. Bit i of a sent character is sampled 8+16i ticks after the first low. The guard NACK is driven from tick 168 to tick 184 of that count, and `tx_done_o` is checked at tick 184. On receive, `rx_valid_o` is checked at the 153rd tick edge and the error pulse at post-parity ticks 9 through 24. The return of `tx_ready_o` is checked on both sides of tick 168 or tick 184, depending on mode. The bench samples on the falling clock edge after each counted tick edge, and it changes the tick divider between characters so the results do not depend on the tick rate.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_BUSY} rx_state_e;

  function automatic logic even_par(input logic [7:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/sc_tx.sv
module sc_tx #(
  parameter int OS = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  input  logic          line_i,
  output logic          busy_o,
  output logic          drv_o,
  output logic          done_o,
  output logic          nack_o
);
  localparam int HALF    = OS / 2;
  localparam int NB      = DW + 2;
  localparam int GUARD   = HALF + NB * OS;
  localparam int NACK_AT = GUARD + OS;
  localparam int DONE_AT = GUARD + OS + HALF - 1;
  localparam int CW      = $clog2(DONE_AT + 1);

  logic [CW-1:0] cnt_q;
  logic [DW:0]   frm_q;
  logic          busy_q, drv_q, done_q, nack_q;

  // level to drive for tick position c: 1 = pull low
  function automatic logic drive_at(input int c, input logic [DW:0] f);
    int idx;
    if (c < HALF || c >= GUARD) return 1'b0;
    idx = (c - HALF) / OS;
    if (idx == 0) return 1'b1;
    return ~f[idx-1];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      frm_q  <= '0;
      busy_q <= 1'b0;
      drv_q  <= 1'b0;
      done_q <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        drv_q  <= 1'b0;
        nack_q <= 1'b0;
        frm_q  <= {^data_i, data_i};
      end else if (busy_q && tick_i) begin
        cnt_q <= cnt_q + 1'b1;
        drv_q <= drive_at(int'(cnt_q) + 1, frm_q);
        if (cnt_q == CW'(NACK_AT)) nack_q <= ~line_i;
        if (cnt_q == CW'(DONE_AT)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          drv_q  <= 1'b0;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign drv_o  = drv_q;
  assign done_o = done_q;
  assign nack_o = nack_q;

  AST_TX_LEAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (int'(cnt_q) < HALF) |-> !drv_q); // R2
  AST_TX_GUARD_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (int'(cnt_q) >= GUARD) |-> !drv_q); // R4
  AST_TX_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R4
  AST_TX_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !drv_q); // R10
endmodule

// File: rtl/sc_rx.sv
module sc_rx #(
  parameter int OS = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          half_stop_i,
  input  logic          line_i,
  output logic          busy_o,
  output logic          drv_o,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          perr_o
);
  import sc_pkg::*;

  localparam int HALF     = OS / 2;
  localparam int NB       = DW + 2;
  localparam int PAR_AT   = HALF + (NB - 1) * OS;
  localparam int ERR_ON   = NB * OS + HALF;
  localparam int END_FULL = ERR_ON + OS;
  localparam int CW       = $clog2(END_FULL + 1);

  rx_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q, data_q;
  logic          drv_q, valid_q, perr_q;

  int   pos, idx;
  logic samp;

  always_comb begin
    pos  = int'(cnt_q);
    samp = (pos >= HALF) && (pos <= PAR_AT) && (((pos - HALF) % OS) == 0);
    idx  = samp ? (pos - HALF) / OS : 0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      drv_q   <= 1'b0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (st_q == RX_IDLE) begin
        if (en_i && tick_i && !line_i) begin
          st_q  <= RX_BUSY;
          cnt_q <= CW'(1);
        end
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
        if (samp) begin
          if (idx == 0) begin
            if (line_i) st_q <= RX_IDLE;  // glitch, not a start bit
          end else if (idx <= DW) begin
            sh_q <= {line_i, sh_q[DW-1:1]};
          end else begin
            data_q  <= sh_q;
            perr_q  <= ^{sh_q, line_i};
            valid_q <= 1'b1;
          end
        end
        if (pos == ERR_ON) begin
          if (perr_q) drv_q <= 1'b1;
          else if (half_stop_i) st_q <= RX_IDLE;
        end
        if (pos == END_FULL) begin
          drv_q <= 1'b0;
          st_q  <= RX_IDLE;
        end
      end
    end
  end

  assign busy_o  = (st_q == RX_BUSY);
  assign drv_o   = drv_q;
  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign perr_o  = perr_q;

  AST_RX_DRV_ONLY_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_q |-> perr_q); // R8
  AST_RX_DRV_AFTER_PAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_q |-> (int'(cnt_q) > PAR_AT)); // R8
  AST_RX_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_IDLE) |-> !drv_q); // R8
  AST_RX_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R7
endmodule

// File: rtl/sc_xcvr.sv
module sc_xcvr #(
  parameter int OS = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rx_half_stop_i,
  input  logic          tx_valid_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          tx_ready_o,
  output logic          tx_done_o,
  output logic          tx_nack_o,
  output logic          line_drive_low_o,
  input  logic          line_i,
  output logic          rx_valid_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_perr_o
);
  logic tx_busy, tx_drv, rx_busy, rx_drv, accept, rx_en;

  assign tx_ready_o = ~tx_busy & ~rx_busy;
  assign accept     = tx_valid_i & tx_ready_o;
  assign rx_en      = ~tx_busy & ~accept;  // transmit wins a same-cycle race

  sc_tx #(.OS(OS), .DW(DW)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .start_i(accept),
    .data_i (tx_data_i),
    .line_i (line_i),
    .busy_o (tx_busy),
    .drv_o  (tx_drv),
    .done_o (tx_done_o),
    .nack_o (tx_nack_o)
  );

  sc_rx #(.OS(OS), .DW(DW)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .en_i       (rx_en),
    .half_stop_i(rx_half_stop_i),
    .line_i     (line_i),
    .busy_o     (rx_busy),
    .drv_o      (rx_drv),
    .valid_o    (rx_valid_o),
    .data_o     (rx_data_o),
    .perr_o     (rx_perr_o)
  );

  assign line_drive_low_o = tx_drv | rx_drv;

  AST_ONE_DRIVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_drv && rx_drv)); // R10
  AST_READY_HALFDUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_busy |-> !tx_ready_o); // R1
  AST_RX_SILENT_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy |-> !rx_valid_o); // R10
endmodule

// File: tb/tb_sc_xcvr.sv
module tb_sc_xcvr;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, half_stop = 1'b0;
  logic       tx_valid = 1'b0, card_low = 1'b0;
  logic [7:0] tx_data = '0;
  wire        tx_ready, tx_done, tx_nack, drv, rx_valid, rx_perr, line;
  wire  [7:0] rx_data;
  int n_run = 0, n_fail = 0, div = 1, div_cnt = 0, rxv_cnt = 0, cyc = 0;

  assign line = ~(drv | card_low);

  sc_xcvr dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rx_half_stop_i(half_stop),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .tx_done_o(tx_done), .tx_nack_o(tx_nack), .line_drive_low_o(drv),
    .line_i(line), .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_perr_o(rx_perr)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin
      tick <= 1'b0; div_cnt <= 0;
    end else if (div_cnt == 0) begin
      tick <= 1'b1; div_cnt <= div - 1;
    end else begin
      tick <= 1'b0; div_cnt <= div_cnt - 1;
    end
  end

  always @(posedge clk) if (rst_n && rx_valid) rxv_cnt <= rxv_cnt + 1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog (all R): cycles actual=%0d expected below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tk();
    do @(posedge clk); while (!tick);
    @(negedge clk);
  endtask

  task automatic tx_char(input logic [7:0] d, input logic nk);
    logic [9:0] got;
    int lead, base, bad_guard;
    got = '0; bad_guard = 0; base = rxv_cnt;
    chk("R1", tx_ready, 1, "ready before send");
    tx_data = d; tx_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    tx_valid = 1'b0;
    chk("R1", tx_ready, 0, "ready while sending");
    lead = 0;
    do begin tk(); lead++; end while (line === 1'b1 && lead < 64);
    chk("R2", lead, 8, "start lead ticks");
    for (int j = 1; j <= 184; j++) begin
      tk();
      if (j == 15) chk("R2", line, 0, "start held low");
      if (j >= 8 && j <= 152 && ((j - 8) % 16) == 0) got[(j - 8) / 16] = line;
      if (j >= 160 && drv) bad_guard++;
      if (j == 168) card_low = nk;
      if (j == 184) begin
        card_low = 1'b0;
        chk("R4", tx_done, 1, "done pulse at guard end");
        chk("R5", tx_nack, nk, "nack flag");
        chk("R1", tx_ready, 1, "ready after done");
      end
    end
    chk("R3", got[0], 0, "start bit");
    chk("R3", got[8:1], d, "data bits lsb first");
    chk("R3", got[9], ^d, "even parity bit");
    chk("R4", bad_guard, 0, "guard released");
    tk();
    chk("R4", tx_done, 0, "done one cycle");
    chk("R5", tx_nack, nk, "nack held");
    chk("R10", rxv_cnt, base, "no receive while sending");
  endtask

  task automatic rx_char(input logic [7:0] d, input logic bp, input logic hs);
    logic [9:0] fr;
    int first, lows, base, fdrv, endj;
    fr = {(^d) ^ bp, d, 1'b0};
    first = -1; lows = 0; fdrv = 0; base = rxv_cnt;
    endj = (hs && !bp) ? 9 : 25;
    half_stop = hs;
    for (int i = 0; i < 10; i++) begin
      card_low = ~fr[i];
      for (int k = 0; k < 16; k++) begin
        tk();
        if (drv) fdrv++;
        if (i == 0 && k == 0) chk("R1", tx_ready, 0, "ready low during receive");
        if (i == 9 && k == 8) begin
          chk("R7", rx_valid, 1, "valid after tick 152");
          chk("R7", rx_data, d, "received byte");
          chk("R7", rx_perr, bp, "parity error flag");
        end
      end
    end
    card_low = 1'b0;
    for (int j = 1; j <= 30; j++) begin
      tk();
      if (drv) begin lows++; if (first < 0) first = j; end
      if (j == endj - 1) chk("R9", tx_ready, 0, "still receiving");
      if (j == endj) chk("R9", tx_ready, 1, "reception ended");
    end
    chk("R8", fdrv, 0, "no drive during frame");
    chk("R8", lows, bp ? 16 : 0, "error pulse length");
    if (bp) chk("R8", first, 9, "error pulse start");
    chk("R7", rxv_cnt, base + 1, "one valid pulse");
  endtask

  initial begin
    int base;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk("R1", tx_ready, 1, "reset ready");
    chk("R10", drv, 0, "reset released");
    chk("R7", rx_valid, 0, "reset no valid");
    chk("R4", tx_done, 0, "reset no done");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    rx_char(8'hA5, 1'b0, 1'b0);
    rx_char(8'h3C, 1'b1, 1'b0);
    rx_char(8'h00, 1'b0, 1'b1);
    rx_char(8'hFF, 1'b1, 1'b1);
    tx_char(8'h5A, 1'b0);
    tx_char(8'h81, 1'b1);
    tx_char(8'h00, 1'b1);
    tx_char(8'hFE, 1'b0);

    // short low glitch: not a start bit (R6)
    base = rxv_cnt;
    card_low = 1'b1;
    repeat (4) tk();
    chk("R6", tx_ready, 0, "start seen");
    card_low = 1'b0;
    repeat (8) tk();
    chk("R6", tx_ready, 1, "false start dropped");
    repeat (200) tk();
    chk("R6", rxv_cnt, base, "no valid after glitch");
    chk("R6", drv, 0, "no drive after glitch");

    for (int n = 0; n < 24; n++) begin
      div = 1 + int'($urandom % 3);
      repeat (3) tk();
      if ($urandom % 2) rx_char(8'($urandom), 1'($urandom % 2), 1'($urandom % 2));
      else              tx_char(8'($urandom), 1'($urandom % 2));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule